// File: doc/BRIEF.md
# Tear-Free Frame Transfer Start Controller

This block decides the clock cycle in which a rectangular frame-area transfer to an external display panel may begin. The aim is that pixel writes never overtake the panel's own scan, which would leave a torn image. The panel reports its scan position on sync outputs. Two wirings are supported. In the first, horizontal and vertical sync arrive on separate pins. In the second, both share a single pin and are told apart only by how long each pulse lasts. The block measures every pulse in functional-clock ticks and classifies it as horizontal sync, vertical sync or noise. It counts lines from the most recent vertical sync and starts the armed transfer when the count reaches a programmed line.

When sync gating is turned off, software starts the transfer with a trigger bit, and the hardware clears that bit itself. Once a transfer is running, the block counts down the pixels that the downstream data path accepts. On the last pixel it drops the enable and gives a one-cycle completion pulse. The pixel data path and the bus strobe timing are not part of this block.

Top module: `tear_xfer_trigger`

## Requirements
- R1: After synchronous reset, xfer_en, xfer_active, xfer_start, xfer_done, kick_pend, hs_evt and vs_evt are 0, line_no is 0 and pix_left is 0.
- R2: A one-cycle arm while idle latches cfg_pix_count into pix_left and sets xfer_en. An arm with a count of 0 is ignored, and an arm while xfer_en is already 1 is ignored.
- R3: With cfg_mode 0 or 3 (sync gating off), sw_kick while armed sets kick_pend on the next edge. The transfer then starts on the edge after that, which also clears kick_pend. sw_kick while idle, or in a sync mode, has no effect.
- R4: Each pix_take while xfer_active decrements pix_left. The take that brings pix_left to 0 clears xfer_en and xfer_active and raises xfer_done for exactly one cycle on the next edge. pix_take while not active leaves pix_left unchanged.
- R5: A pulse's width is the number of consecutive clock edges at which the pin is sampled at its asserted level. A polarity input of 1 means the pin is asserted high; 0 means it is asserted low. Each pulse is classified at the edge where the pin is first sampled deasserted.
- R6: In cfg_mode 2 (two pins), a pulse on sync_h_in at least cfg_hs_width long is a horizontal sync. A pulse on sync_v_in at least cfg_vs_width long is a vertical sync. Shorter pulses are ignored. If both are classified in the same cycle, only the vertical sync counts.
- R7: In cfg_mode 1 (one pin), only sync_h_in is used, with cfg_hs_pol. A pulse at least cfg_vs_width long is a vertical sync. A pulse shorter than that but at least cfg_hs_width long is a horizontal sync. Shorter pulses are ignored, and sync_v_in has no effect.
- R8: No sync event is produced if cfg_hs_width is below 2, or if cfg_vs_width is below 2 (mode 2) or below 4 (mode 1), or if the two widths are equal.
- R9: A vertical sync sets line_no to 0 and marks a frame as seen. A horizontal sync adds 1 to line_no, saturating at 2047. Each event shows on hs_evt/vs_evt one edge after classification, and line_no changes one edge later.
- R10: In mode 1 or 2, an armed transfer starts at the first edge where a frame has been seen and line_no equals cfg_line.
- R11: xfer_start is a one-cycle pulse that rises on the same edge as xfer_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0/3 gating off, 1 one-pin sync, 2 two-pin sync |
| cfg_hs_width | input | 8 | Horizontal sync width threshold, ticks |
| cfg_vs_width | input | 8 | Vertical sync width threshold, ticks |
| cfg_hs_pol | input | 1 | sync_h_in asserted level (1 high, 0 low) |
| cfg_vs_pol | input | 1 | sync_v_in asserted level (1 high, 0 low) |
| cfg_line | input | 11 | Line at which a gated transfer starts |
| cfg_pix_count | input | 20 | Pixels in the area (width times height) |
| arm | input | 1 | Arm a transfer |
| sw_kick | input | 1 | Software start request when gating is off |
| pix_take | input | 1 | Data path accepted one pixel |
| sync_h_in | input | 1 | Horizontal sync pin, or the shared sync pin |
| sync_v_in | input | 1 | Vertical sync pin |
| xfer_en | output | 1 | Transfer enabled (armed or running) |
| xfer_active | output | 1 | Transfer running |
| xfer_start | output | 1 | One-cycle start pulse |
| xfer_done | output | 1 | One-cycle completion pulse |
| kick_pend | output | 1 | Software trigger bit |
| hs_evt | output | 1 | Horizontal sync classified |
| vs_evt | output | 1 | Vertical sync classified |
| line_no | output | 11 | Lines since the last vertical sync |
| pix_left | output | 20 | Pixels still to transfer |

## Verification
A wrong width counter or a wrong classification shows on hs_evt or vs_evt one edge after the pulse ends, and on line_no one edge later. Every pulse in the mixed random and directed sweeps is therefore checked three cycles after it ends. A wrong transfer state shows at once: xfer_active, pix_left or the enable moves in the wrong cycle, or a start or done pulse is missing. The bench checks each of these outputs cycle by cycle against its own count of the pixels taken.

// File: rtl/tear_pkg.sv
`timescale 1ns/1ps
package tear_pkg;

    typedef enum logic [1:0] {
        SYNC_OFF     = 2'd0,
        SYNC_ONE_PIN = 2'd1,
        SYNC_TWO_PIN = 2'd2,
        SYNC_RSVD    = 2'd3
    } sync_mode_e;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ARMED = 2'd1,
        XS_RUN   = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic hsync;
        logic vsync;
    } sync_evt_t;

    localparam int unsigned HS_MIN_TICKS     = 2;
    localparam int unsigned VS_MIN_TWO_TICKS = 2;
    localparam int unsigned VS_MIN_ONE_TICKS = 4;

    // Channel indices of the measured pins
    localparam int CH_H = 0;
    localparam int CH_V = 1;
    localparam int N_CH = 2;

    function automatic logic sync_mode_on(input sync_mode_e m);
        return (m == SYNC_ONE_PIN) || (m == SYNC_TWO_PIN);
    endfunction

    function automatic logic thr_valid(input sync_mode_e m,
                                       input int unsigned hs_thr,
                                       input int unsigned vs_thr);
        int unsigned vs_min;
        vs_min = (m == SYNC_ONE_PIN) ? VS_MIN_ONE_TICKS : VS_MIN_TWO_TICKS;
        return (hs_thr >= HS_MIN_TICKS) && (vs_thr >= vs_min) && (hs_thr != vs_thr);
    endfunction

    // Classify pulse ends into sync events. Vertical wins over horizontal.
    function automatic sync_evt_t classify(input sync_mode_e  m,
                                           input logic        ok,
                                           input logic        h_end,
                                           input int unsigned h_w,
                                           input logic        v_end,
                                           input int unsigned v_w,
                                           input int unsigned hs_thr,
                                           input int unsigned vs_thr);
        sync_evt_t e;
        e = '0;
        if (ok) begin
            case (m)
                SYNC_ONE_PIN: begin
                    if (h_end) begin
                        if (h_w >= vs_thr)      e.vsync = 1'b1;
                        else if (h_w >= hs_thr) e.hsync = 1'b1;
                    end
                end
                SYNC_TWO_PIN: begin
                    e.vsync = v_end && (v_w >= vs_thr);
                    e.hsync = h_end && (h_w >= hs_thr) && !e.vsync;
                end
                default: e = '0;
            endcase
        end
        return e;
    endfunction

endpackage

// File: rtl/sync_pulse_meas.sv
`timescale 1ns/1ps
module sync_pulse_meas #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic             pol,
    output logic             pulse_end,
    output logic [CNT_W-1:0] pulse_w
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             lvl;
    logic             lvl_q;
    logic [CNT_W-1:0] run_cnt;

    assign lvl = pol ? raw : ~raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= 1'b0;
            run_cnt <= '0;
        end else begin
            lvl_q <= lvl;
            if (lvl) begin
                if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end

    // Pulse ends when the pin is first seen deasserted; width is the run so far
    assign pulse_end = lvl_q & ~lvl;
    assign pulse_w   = run_cnt;
endmodule

// File: rtl/sync_line_tracker.sv
`timescale 1ns/1ps
module sync_line_tracker
    import tear_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_mode_e        mode,
    input  logic [CNT_W-1:0]  hs_thr,
    input  logic [CNT_W-1:0]  vs_thr,
    input  logic              h_end,
    input  logic [CNT_W-1:0]  h_w,
    input  logic              v_end,
    input  logic [CNT_W-1:0]  v_w,
    output sync_evt_t         evt,
    output logic [LINE_W-1:0] line_no,
    output logic              frame_seen
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic      cfg_ok;
    sync_evt_t evt_d;
    sync_evt_t evt_q;
    logic [LINE_W-1:0] line_q;
    logic              seen_q;

    assign cfg_ok = thr_valid(mode, 32'(hs_thr), 32'(vs_thr));
    assign evt_d  = classify(mode, cfg_ok, h_end, 32'(h_w), v_end, 32'(v_w),
                             32'(hs_thr), 32'(vs_thr));

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            line_q <= '0;
            seen_q <= 1'b0;
        end else begin
            evt_q <= evt_d;
            if (evt_q.vsync) begin
                line_q <= '0;
                seen_q <= 1'b1;
            end else if (evt_q.hsync && (line_q != LINE_MAX)) begin
                line_q <= line_q + 1'b1;
            end
        end
    end

    assign evt        = evt_q;
    assign line_no    = line_q;
    assign frame_seen = seen_q;
endmodule

// File: rtl/xfer_sequencer.sv
`timescale 1ns/1ps
module xfer_sequencer
    import tear_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_mode_e        mode,
    input  logic              arm,
    input  logic [PIX_W-1:0]  pix_count,
    input  logic              sw_kick,
    input  logic              pix_take,
    input  logic [LINE_W-1:0] line_no,
    input  logic              frame_seen,
    input  logic [LINE_W-1:0] cfg_line,
    output logic              xfer_en,
    output logic              xfer_active,
    output logic              xfer_start,
    output logic              xfer_done,
    output logic              kick_pend,
    output logic [PIX_W-1:0]  pix_left
);
    xfer_state_e      state_q;
    logic [PIX_W-1:0] left_q;
    logic             kick_q;
    logic             start_q;
    logic             done_q;
    logic             gated;
    logic             line_hit;
    logic             go;

    assign gated    = sync_mode_on(mode);
    assign line_hit = frame_seen && (line_no == cfg_line);
    assign go       = gated ? line_hit : kick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            left_q  <= '0;
            kick_q  <= 1'b0;
            start_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                XS_IDLE: begin
                    kick_q <= 1'b0;
                    if (arm && (pix_count != '0)) begin
                        left_q  <= pix_count;
                        state_q <= XS_ARMED;
                    end
                end
                XS_ARMED: begin
                    if (go) begin
                        state_q <= XS_RUN;
                        start_q <= 1'b1;
                        kick_q  <= 1'b0;
                    end else if (gated) begin
                        kick_q <= 1'b0;
                    end else if (sw_kick) begin
                        kick_q <= 1'b1;
                    end
                end
                XS_RUN: begin
                    kick_q <= 1'b0;
                    if (pix_take) begin
                        if (left_q == PIX_W'(1)) begin
                            left_q  <= '0;
                            state_q <= XS_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign xfer_en     = (state_q != XS_IDLE);
    assign xfer_active = (state_q == XS_RUN);
    assign xfer_start  = start_q;
    assign xfer_done   = done_q;
    assign kick_pend   = kick_q;
    assign pix_left    = left_q;
endmodule

// File: rtl/tear_xfer_trigger.sv
`timescale 1ns/1ps
module tear_xfer_trigger
    import tear_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 11,
    parameter int PIX_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  cfg_hs_width,
    input  logic [CNT_W-1:0]  cfg_vs_width,
    input  logic              cfg_hs_pol,
    input  logic              cfg_vs_pol,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic [PIX_W-1:0]  cfg_pix_count,
    input  logic              arm,
    input  logic              sw_kick,
    input  logic              pix_take,
    input  logic              sync_h_in,
    input  logic              sync_v_in,
    output logic              xfer_en,
    output logic              xfer_active,
    output logic              xfer_start,
    output logic              xfer_done,
    output logic              kick_pend,
    output logic              hs_evt,
    output logic              vs_evt,
    output logic [LINE_W-1:0] line_no,
    output logic [PIX_W-1:0]  pix_left
);
    sync_mode_e        mode;
    logic [N_CH-1:0]   ch_raw;
    logic [N_CH-1:0]   ch_pol;
    logic [N_CH-1:0]   ch_end;
    logic [CNT_W-1:0]  ch_w [N_CH];
    sync_evt_t         evt;
    logic              frame_seen;

    assign mode         = sync_mode_e'(cfg_mode);
    assign ch_raw[CH_H] = sync_h_in;
    assign ch_raw[CH_V] = sync_v_in;
    assign ch_pol[CH_H] = cfg_hs_pol;
    assign ch_pol[CH_V] = cfg_vs_pol;

    for (genvar c = 0; c < N_CH; c++) begin : g_meas
        sync_pulse_meas #(.CNT_W(CNT_W)) u_meas (
            .clk      (clk),
            .rst      (rst),
            .raw      (ch_raw[c]),
            .pol      (ch_pol[c]),
            .pulse_end(ch_end[c]),
            .pulse_w  (ch_w[c])
        );
    end

    sync_line_tracker #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .hs_thr    (cfg_hs_width),
        .vs_thr    (cfg_vs_width),
        .h_end     (ch_end[CH_H]),
        .h_w       (ch_w[CH_H]),
        .v_end     (ch_end[CH_V]),
        .v_w       (ch_w[CH_V]),
        .evt       (evt),
        .line_no   (line_no),
        .frame_seen(frame_seen)
    );

    xfer_sequencer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .arm        (arm),
        .pix_count  (cfg_pix_count),
        .sw_kick    (sw_kick),
        .pix_take   (pix_take),
        .line_no    (line_no),
        .frame_seen (frame_seen),
        .cfg_line   (cfg_line),
        .xfer_en    (xfer_en),
        .xfer_active(xfer_active),
        .xfer_start (xfer_start),
        .xfer_done  (xfer_done),
        .kick_pend  (kick_pend),
        .pix_left   (pix_left)
    );

    assign hs_evt = evt.hsync;
    assign vs_evt = evt.vsync;
endmodule

// File: rtl/tear_xfer_trigger_chk.sv
`timescale 1ns/1ps
module tear_xfer_trigger_chk #(
    parameter int LINE_W = 11,
    parameter int PIX_W  = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              hs_evt,
    input logic              vs_evt,
    input logic [LINE_W-1:0] line_no,
    input logic              xfer_en,
    input logic              xfer_active,
    input logic              xfer_start,
    input logic              xfer_done,
    input logic              kick_pend,
    input logic              pix_take,
    input logic [PIX_W-1:0]  pix_left
);
    localparam logic [LINE_W-1:0] LINE_TOP = '1;

    a_r4_done_drops_enable: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (!xfer_en && !xfer_active));

    a_r4_count_steps_down: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && pix_take && (pix_left > PIX_W'(1))) |=> (pix_left == $past(pix_left) - 1'b1));

    a_r11_start_single: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    a_r11_start_with_active: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> xfer_active);

    a_r3_kick_self_clears: assert property (@(posedge clk) disable iff (rst)
        kick_pend |=> !kick_pend);

    a_r6_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hs_evt && vs_evt));

    a_r9_vsync_zeroes_line: assert property (@(posedge clk) disable iff (rst)
        vs_evt |=> (line_no == '0));

    a_r9_hsync_steps_line: assert property (@(posedge clk) disable iff (rst)
        (hs_evt && (line_no != LINE_TOP)) |=> (line_no == $past(line_no) + 1'b1));
endmodule

bind tear_xfer_trigger tear_xfer_trigger_chk #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/tear_xfer_trigger_bench.sv
`timescale 1ns/1ps
module tear_xfer_trigger_bench;
    localparam int CNT_W  = 8;
    localparam int LINE_W = 11;
    localparam int PIX_W  = 20;
    localparam int LINE_MAX = (1 << LINE_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cfg_mode = 2'd0;
    logic [CNT_W-1:0]  cfg_hs_width = 8'd3;
    logic [CNT_W-1:0]  cfg_vs_width = 8'd6;
    logic              cfg_hs_pol = 1'b1;
    logic              cfg_vs_pol = 1'b1;
    logic [LINE_W-1:0] cfg_line = '0;
    logic [PIX_W-1:0]  cfg_pix_count = '0;
    logic              arm = 1'b0;
    logic              sw_kick = 1'b0;
    logic              pix_take = 1'b0;
    logic              sync_h_in = 1'b0;
    logic              sync_v_in = 1'b0;
    logic              xfer_en, xfer_active, xfer_start, xfer_done, kick_pend;
    logic              hs_evt, vs_evt;
    logic [LINE_W-1:0] line_no;
    logic [PIX_W-1:0]  pix_left;

    int vectors = 0;
    int miscompares = 0;
    int exp_line = 0;

    always #10 clk = ~clk;

    tear_xfer_trigger #(.CNT_W(CNT_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) u_tear_xfer_trigger (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected classification of one pulse on the shared pin (R7) / h pin
    function automatic int line_after(input int cur, input int w, input int mode,
                                      input int hs, input int vs);
        int vmin;
        vmin = (mode == 1) ? 4 : 2;
        if (hs < 2 || vs < vmin || hs == vs) return cur;
        if (mode == 1 && w >= vs) return 0;
        if (w >= hs) return (cur == LINE_MAX) ? cur : cur + 1;
        return cur;
    endfunction

    task automatic pulse(input bit on_v, input int w);
        if (on_v) sync_v_in = cfg_vs_pol; else sync_h_in = cfg_hs_pol;
        ticks(w);
        if (on_v) sync_v_in = ~cfg_vs_pol; else sync_h_in = ~cfg_hs_pol;
        ticks(3);
    endtask

    task automatic arm_with(input int n);
        cfg_pix_count = PIX_W'(n);
        arm = 1'b1;
        ticks(1);
        arm = 1'b0;
        ticks(1);
    endtask

    // Drain an active transfer with random take pattern, checking each step (R4)
    task automatic drain(input int n);
        int rem;
        rem = n;
        while (rem > 0) begin
            pix_take = ($urandom_range(0, 1) == 1) || (rem == 1 && $urandom_range(0, 3) == 0);
            ticks(1);
            if (pix_take) rem--;
            if (rem > 0) begin
                chk("R4 pix_left", pix_left, rem);
                chk("R4 active", xfer_active, 1);
            end else begin
                chk("R4 done pulse", xfer_done, 1);
                chk("R4 enable cleared", xfer_en, 0);
                chk("R4 active cleared", xfer_active, 0);
            end
        end
        pix_take = 1'b0;
        ticks(1);
        chk("R4 done one cycle", xfer_done, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        ticks(3);
        rst = 1'b0;
        ticks(1);
        // R1 reset state
        chk("R1 xfer_en", xfer_en, 0);
        chk("R1 active", xfer_active, 0);
        chk("R1 start", xfer_start, 0);
        chk("R1 done", xfer_done, 0);
        chk("R1 kick", kick_pend, 0);
        chk("R1 events", {hs_evt, vs_evt}, 0);
        chk("R1 line", line_no, 0);
        chk("R1 pix_left", pix_left, 0);

        // R2 zero-count arm ignored, arm while enabled ignored
        arm_with(0);
        chk("R2 zero count ignored", xfer_en, 0);
        sw_kick = 1'b1; ticks(1); sw_kick = 1'b0; ticks(1);
        chk("R3 kick while idle ignored", kick_pend, 0);
        chk("R3 kick while idle no start", xfer_active, 0);
        arm_with(4);
        chk("R2 enable set", xfer_en, 1);
        chk("R2 count latched", pix_left, 4);
        arm_with(9);
        chk("R2 rearm ignored", pix_left, 4);
        pix_take = 1'b1; ticks(3); pix_take = 1'b0;
        chk("R4 take while armed ignored", pix_left, 4);

        // R3 software kick, R11 start pulse
        sw_kick = 1'b1; ticks(1); sw_kick = 1'b0;
        chk("R3 kick set", kick_pend, 1);
        chk("R3 not yet active", xfer_active, 0);
        ticks(1);
        chk("R3 kick cleared", kick_pend, 0);
        chk("R11 start rises", xfer_start, 1);
        chk("R11 active rises", xfer_active, 1);
        ticks(1);
        chk("R11 start one cycle", xfer_start, 0);
        drain(4);

        // R4 random counts, reserved mode 3 behaves as off (R3)
        for (int i = 0; i < 6; i++) begin
            int n;
            n = (i == 0) ? 1 : $urandom_range(2, 20);
            cfg_mode = (i % 2 == 0) ? 2'd0 : 2'd3;
            arm_with(n);
            sw_kick = 1'b1; ticks(1); sw_kick = 1'b0; ticks(1);
            chk("R3 kicked start", xfer_active, 1);
            drain(n);
        end
        cfg_mode = 2'd0;

        // Two-pin gating: R6, R9, R10
        cfg_mode = 2'd2; cfg_line = 11'd3;
        arm_with(2);
        sw_kick = 1'b1; ticks(1); sw_kick = 1'b0; ticks(2);
        chk("R10 kick ignored in sync mode", xfer_active, 0);
        chk("R10 kick bit stays clear", kick_pend, 0);
        pulse(1'b1, 6); exp_line = 0;
        chk("R9 vsync zeroes line", line_no, 0);
        pulse(1'b0, 3); chk("R6 hsync counts", line_no, 1);
        pulse(1'b0, 2); chk("R6 short pulse ignored", line_no, 1);
        pulse(1'b1, 5); chk("R6 short vsync ignored", line_no, 1);
        pulse(1'b0, 3); chk("R9 line two", line_no, 2);
        chk("R10 no start before line", xfer_active, 0);
        pulse(1'b0, 4); chk("R9 line three", line_no, 3);
        chk("R10 started at line", xfer_active, 1);
        drain(2);
        // R6 simultaneous pulses: vertical wins
        sync_h_in = 1'b1; sync_v_in = 1'b1; ticks(6);
        sync_h_in = 1'b0; sync_v_in = 1'b0; ticks(3);
        exp_line = 0;
        chk("R6 vsync priority", line_no, 0);

        // R8 invalid thresholds suppress events
        cfg_hs_width = 8'd1;
        pulse(1'b0, 5); chk("R8 hs below 2", line_no, 0);
        cfg_hs_width = 8'd4; cfg_vs_width = 8'd4;
        pulse(1'b0, 5); chk("R8 equal widths", line_no, 0);
        cfg_hs_width = 8'd3; cfg_vs_width = 8'd6;
        pulse(1'b0, 3); exp_line = 1; chk("R8 valid again", line_no, 1);
        cfg_mode = 2'd1; cfg_hs_width = 8'd2; cfg_vs_width = 8'd3;
        pulse(1'b0, 5); chk("R8 one-pin vs below 4", line_no, 1);

        // R7 + R5 one-pin random sweep, shared pin asserted low
        cfg_hs_width = 8'd3; cfg_vs_width = 8'd7;
        cfg_hs_pol = 1'b0; sync_h_in = 1'b1;
        ticks(2);
        for (int i = 0; i < 60; i++) begin
            int w;
            if (i % 6 == 5) begin
                pulse(1'b1, 9);
                chk("R7 v pin ignored", line_no, exp_line);
            end else begin
                w = (i == 0) ? 7 : (i == 1) ? 6 : (i == 2) ? 3 : (i == 3) ? 2 : $urandom_range(1, 10);
                pulse(1'b0, w);
                exp_line = line_after(exp_line, w, 1, 3, 7);
                chk("R7 one-pin classification", line_no, exp_line);
            end
        end

        // R10 one-pin start at line 0 right after vsync
        cfg_line = 11'd0;
        arm_with(1);
        chk("R10 armed", xfer_en, 1);
        pulse(1'b0, 8); exp_line = 0;
        chk("R10 start on vsync line 0", xfer_active, 1);
        drain(1);

        // R9 saturation, two-pin, both pins asserted high
        cfg_mode = 2'd2; cfg_hs_pol = 1'b1; sync_h_in = 1'b0;
        cfg_hs_width = 8'd2; cfg_vs_width = 8'd4;
        ticks(2);
        pulse(1'b1, 4); exp_line = 0;
        for (int i = 0; i < LINE_MAX + 3; i++) pulse(1'b0, 2);
        chk("R9 line saturates", line_no, LINE_MAX);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #3_000_000;
        miscompares++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule